// File: doc/BRIEF.md
# Level Register Serial Loader

This block is a serial master that fills the waveform level registers of an ultrasound transmit driver. The driver holds fifteen pulse-amplitude levels and one 8-bit amplitude DAC setting. On a start command the loader captures a table of fifteen 7-bit magnitudes and a DAC byte. It builds a 128-bit image and adds the sign bit of each level from the level's position: the low-numbered levels drive one output side and are positive, the rest are negative. It shifts the image out with chip-select held low. It then pulses the load strobe so the driver moves the shifted data into its active registers.

When the verify option is set with the start command, the loader opens a second chip-select window right after the load strobe. It shifts the same image out again, compares every bit returned on the serial data input against the bit it expects, and reports any difference on a sticky error output. The serial clock is the system clock divided by two, so a 250 MHz system clock gives a 125 MHz bit clock. At that rate a complete reload with verify takes about 516 system cycles and fits between scans.

Top module: `lvl_spi_loader`

## Requirements
- R1: During reset and after it, cs_n=1, sck=0, sdi=0, ld=0, busy=0, done=0, err=0.
- R2: A start sampled while idle drives cs_n low from the next cycle for exactly 2*128 = 256 clock cycles.
- R3: While cs_n is low, sck is low in the first clock cycle of each bit and high in the second. sck is 0 whenever cs_n is high.
- R4: The image is sent MSB first in this order: level 1, level 2, … level 15, then the DAC byte. sdi holds each bit during both halves of its bit period, so it changes only as sck falls.
- R5: Each level byte is {sign, magnitude}. The sign is 0 for levels 1–7 and 1 for levels 8–15. The magnitude of level k is lv_mag[(k-1)*7 +: 7].
- R6: After cs_n rises, one cycle follows with ld=0. Then ld is high for exactly two clock cycles (one SCK period). cs_n stays high throughout.
- R7: If verify was 1 at start, cs_n goes low again in the cycle after ld falls. A second 256-cycle pass then sends the same image with the same timing.
- R8: During the verify pass, sdo is sampled at the clock edge where sck rises and is compared with the bit on sdi. After the pass, err is 1 if any bit differed and 0 otherwise. err is cleared by the next accepted start and stays 0 on a run without verify.
- R9: busy is 1 from the cycle after start until the last cycle of the sequence. done is high for exactly one cycle, the first idle cycle (cycle 260 after start, or cycle 516 with verify).
- R10: A start while busy is ignored, and so are changes to lv_mag, dac_val or verify while busy. The image applied is the one captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a load, sampled while idle |
| verify | input | 1 | Request a readback pass, captured with start |
| lv_mag | input | 105 | Fifteen 7-bit level magnitudes, level 1 in the low bits |
| dac_val | input | 8 | Amplitude DAC value |
| sdo | input | 1 | Serial data returned by the driver |
| sck | output | 1 | Serial clock, system clock divided by two |
| sdi | output | 1 | Serial data to the driver |
| cs_n | output | 1 | Active-low chip select |
| ld | output | 1 | Load strobe applying the shifted image |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Readback mismatch seen in the last verify pass |

## Verification
The hardest condition to reach from the ports is a readback mismatch at one exact bit, especially the very first bit and the very last DAC bit. At those positions an off-by-one sampling edge would go unnoticed. The bench models the driver. It shifts in sdi on rising sck, latches the image on ld, and returns it on sdo during the next window. A fault knob inverts one chosen bit index on return, so a mismatch can be placed at bit 0, at bit 127, or nowhere. A start pulsed mid-load with a different table shows the captured image is kept.

// File: rtl/lvl_spi_loader.sv
module lvl_spi_loader #(
  parameter int NUM_LV = 15,
  parameter int POS_LV = 7,
  parameter int MAG_W  = 7,
  parameter int DAC_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    verify,
  input  logic [NUM_LV*MAG_W-1:0] lv_mag,
  input  logic [DAC_W-1:0]        dac_val,
  input  logic                    sdo,
  output logic                    sck,
  output logic                    sdi,
  output logic                    cs_n,
  output logic                    ld,
  output logic                    busy,
  output logic                    done,
  output logic                    err
);
  localparam int LV_W    = MAG_W + 1;
  localparam int FRAME_W = NUM_LV * LV_W + DAC_W;
  localparam int HALF    = 2 * FRAME_W;
  localparam int CNT_W   = $clog2(HALF);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_GAP, S_LD, S_RD} st_t;

  st_t                st;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shr;
  logic [FRAME_W-1:0] frame_w;
  logic               vfy, mis, done_q, err_q;
  logic               shifting, last_half;

  always_comb begin
    frame_w = '0;
    frame_w[DAC_W-1:0] = dac_val;
    for (int k = 0; k < NUM_LV; k++) begin
      frame_w[FRAME_W-1-k*LV_W] = (k >= POS_LV);
      frame_w[FRAME_W-2-k*LV_W -: MAG_W] = lv_mag[k*MAG_W +: MAG_W];
    end
  end

  assign shifting  = (st == S_WR) || (st == S_RD);
  assign last_half = (cnt == CNT_W'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      shr    <= '0;
      vfy    <= 1'b0;
      mis    <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          shr   <= frame_w;
          vfy   <= verify;
          mis   <= 1'b0;
          err_q <= 1'b0;
          cnt   <= '0;
          st    <= S_WR;
        end
        S_WR, S_RD: begin
          if (st == S_RD && !cnt[0] && sdo != shr[FRAME_W-1]) mis <= 1'b1;
          if (cnt[0]) shr <= {shr[FRAME_W-2:0], shr[FRAME_W-1]};
          if (last_half) begin
            cnt <= '0;
            if (st == S_WR) st <= S_GAP;
            else begin
              st     <= S_IDLE;
              done_q <= 1'b1;
              err_q  <= mis;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_GAP: begin
          cnt <= '0;
          st  <= S_LD;
        end
        S_LD: if (cnt[0]) begin
          cnt <= '0;
          if (vfy) st <= S_RD;
          else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sck  = shifting & cnt[0];
  assign sdi  = shifting & shr[FRAME_W-1];
  assign cs_n = ~shifting;
  assign ld   = (st == S_LD);
  assign busy = (st != S_IDLE);
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/lvl_spi_loader_chk.sv
module lvl_spi_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic sdi,
  input logic cs_n,
  input logic ld,
  input logic busy,
  input logic done
);
  a_r6_ld_outside_cs: assert property (@(posedge clk) disable iff (!rst_n) ld |-> cs_n);
  a_r6_gap_after_cs: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> !ld);
  a_r6_ld_two_high: assert property (@(posedge clk) disable iff (!rst_n) $rose(ld) |=> ld);
  a_r6_ld_not_three: assert property (@(posedge clk) disable iff (!rst_n) (ld && $past(ld)) |=> !ld);
  a_r3_sck_in_cs: assert property (@(posedge clk) disable iff (!rst_n) sck |-> !cs_n);
  a_r4_sdi_held: assert property (@(posedge clk) disable iff (!rst_n) sck |-> $stable(sdi));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (cs_n && !ld && !sck));
endmodule

bind lvl_spi_loader lvl_spi_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_n(cs_n),
  .ld(ld), .busy(busy), .done(done)
);

// File: tb/sim_lvl_spi_loader.sv
module sim_lvl_spi_loader;
  localparam int NL = 15, PL = 7, MW = 7, DW = 8;
  localparam int FB = NL * (MW + 1) + DW;
  localparam int W_END = 2 * FB;
  localparam int R_BEG = W_END + 4;
  localparam int R_END = R_BEG + 2 * FB - 1;

  logic clk = 0, rst_n = 0, start = 0, verify = 0;
  logic [NL*MW-1:0] lv_mag = '0;
  logic [DW-1:0] dac_val = '0;
  logic sdo, sck, sdi, cs_n, ld, busy, done, err;

  lvl_spi_loader u0 (.clk(clk), .rst_n(rst_n), .start(start), .verify(verify),
    .lv_mag(lv_mag), .dac_val(dac_val), .sdo(sdo), .sck(sck), .sdi(sdi),
    .cs_n(cs_n), .ld(ld), .busy(busy), .done(done), .err(err));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // driver model
  logic [FB-1:0] dev_sh = '0, dev_act = '0;
  int dev_idx = 0;
  int flip = -1;
  always @(posedge sck or posedge ld) begin
    if (ld) begin
      dev_act <= dev_sh;
      dev_idx <= 0;
    end else if (!cs_n) begin
      dev_sh  <= {dev_sh[FB-2:0], sdi};
      dev_idx <= dev_idx + 1;
    end
  end
  assign sdo = (dev_idx < FB) ? (dev_act[FB-1-dev_idx] ^ (dev_idx == flip)) : 1'b0;

  // reference model
  bit fq[$];
  int mt = 0;
  bit mv, mis_m, done_e, err_e;

  function automatic void make_frame(logic [NL*MW-1:0] m, logic [DW-1:0] d);
    fq.delete();
    for (int k = 0; k < NL; k++) begin
      fq.push_back(k >= PL);
      for (int b = MW - 1; b >= 0; b--) fq.push_back(m[k*MW+b]);
    end
    for (int b = DW - 1; b >= 0; b--) fq.push_back(d[b]);
  endfunction

  function automatic logic [FB-1:0] frame_vec();
    logic [FB-1:0] v = '0;
    for (int i = 0; i < FB; i++) v[FB-1-i] = fq[i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mt = 0; done_e = 0; err_e = 0;
    end else begin
      done_e = 0;
      if (mt == 0) begin
        if (start) begin
          make_frame(lv_mag, dac_val);
          mv = verify; mis_m = 0; err_e = 0; mt = 1;
        end
      end else begin
        if (mv && mt >= R_BEG && mt <= R_END && ((mt - R_BEG) % 2 == 0))
          if (sdo !== fq[(mt - R_BEG) / 2]) mis_m = 1;
        if (mt == (mv ? R_END : W_END + 3)) begin
          mt = 0; done_e = 1; err_e = mv & mis_m;
        end else mt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit in_w, in_r, sh, e_sck, e_sdi;
      int off;
      in_w = (mt >= 1 && mt <= W_END);
      in_r = mv && (mt >= R_BEG && mt <= R_END);
      sh = in_w || in_r;
      off = in_w ? mt - 1 : (in_r ? mt - R_BEG : 0);
      e_sck = sh && (off % 2 == 1);
      e_sdi = sh && fq[off / 2];
      chk(in_r ? "R7" : "R2", "cs_n", cs_n, !sh);
      chk("R3", "sck", sck, e_sck);
      chk("R4", "sdi", sdi, e_sdi);
      chk("R6", "ld", ld, (mt == W_END + 2) || (mt == W_END + 3));
      chk("R9", "busy", busy, mt != 0);
      chk("R9", "done", done, done_e);
      chk("R8", "err", err, err_e);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R9 watchdog actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic wait_idle();
    int n = 0;
    while (mt != 0 && n < 2000) begin
      @(posedge clk);
      n++;
    end
    @(posedge clk); #1;
  endtask

  task automatic kick(logic [NL*MW-1:0] m, logic [DW-1:0] d, bit v);
    @(posedge clk); #1;
    lv_mag = m; dac_val = d; verify = v; start = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic chk_img(string tag);
    checks++;
    if (dev_act !== frame_vec()) begin
      fails++;
      $display("FAIL %s image actual=%h expected=%h", tag, dev_act, frame_vec());
    end
  endtask

  initial begin
    logic [NL*MW-1:0] pa, pz;
    for (int k = 0; k < NL; k++) pa[k*MW +: MW] = MW'(k * 9 + 3);
    pz = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "cs_n", cs_n, 1); chk("R1", "sck", sck, 0); chk("R1", "sdi", sdi, 0);
    chk("R1", "ld", ld, 0); chk("R1", "busy", busy, 0); chk("R1", "done", done, 0);
    chk("R1", "err", err, 0);
    rst_n = 1;
    repeat (2) @(posedge clk);

    kick(pa, 8'hA5, 0); wait_idle(); chk_img("R5");
    flip = -1; kick({NL*MW{1'b1}}, 8'h00, 1); wait_idle(); chk_img("R5");
    chk("R8", "err_clean", err, 0);
    flip = 0; kick(pz, 8'hFF, 1); wait_idle();
    chk("R8", "err_first_bit", err, 1);
    flip = FB - 1; kick(pa, 8'h3C, 1); wait_idle();
    chk("R8", "err_last_bit", err, 1);
    flip = -1; kick(pa, 8'h3C, 1); wait_idle();
    chk("R8", "err_cleared", err, 0);
    chk_img("R7");

    kick(pz, 8'h81, 0);
    repeat (50) @(posedge clk);
    #1;
    lv_mag = {NL*MW{1'b1}}; dac_val = 8'h7E; verify = 1; start = 1;
    @(posedge clk); #1;
    start = 0;
    wait_idle();
    chk_img("R10");
    chk("R10", "busy_after", busy, 0);

    summary();
    $finish;
  end
endmodule